// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block is a JTAG test access port whose data register path can be handed over to an external serial flash. A host drives the TAP pins and loads one user instruction. From then on, every pass through Shift-DR becomes one flash transaction. Chip select follows the TAP state. TDI drives the flash data input. The flash data output comes back on TDO, and TCK doubles as the serial clock. The block generates no separate SPI clock and has no command engine of its own.

Every instruction other than the bridge code selects a single-bit bypass register, and the flash then stays deselected. The host must allow for one bit of latency between what it shifts in and what the flash returns. TDO is driven only during shift states and is otherwise reported as not driven through an output-enable flag.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While rst_ni is low, the TAP is held in Test-Logic-Reset and the instruction register holds all ones (bypass). spi_cs_no is high, tdo_oe_o is low and spi_sclk_o is low. All of this takes effect without waiting for a TCK edge.
- R2: Five consecutive rising TCK edges with tms_i high put the TAP in Test-Logic-Reset from any state, which reloads the instruction register with all ones.
- R3: The instruction register is 6 bits wide and is shifted LSB first. In Capture-IR it loads 6'b000001, so the first bit out on TDO is 1 and the next five are 0. A shifted value becomes the active instruction on the falling TCK edge in Update-IR.
- R4: spi_cs_no is low exactly when the active instruction is 6'h02 and the TAP is in Shift-DR. It is high in Capture-DR, Pause-DR, Exit1-DR, Shift-IR and every other state.
- R5: While the active instruction is 6'h02, spi_mosi_o equals tdi_i, and the flash sees each shifted bit at a rising spi_sclk_o edge. Under any other instruction, spi_mosi_o is 0.
- R6: In bridge Shift-DR, tdo_o takes the value of spi_miso_i present at each falling TCK edge.
- R7: spi_sclk_o follows TCK only while the flash is selected, giving exactly one rising edge per bit shifted in Shift-DR. It gives none in Pause-DR and none under any other instruction.
- R8: Under any instruction other than 6'h02, Shift-DR goes through a 1-bit bypass register that loads 0 in Capture-DR. The first bit out is 0, and after each shifted bit tdo_o equals that bit.
- R9: tdo_o changes only on the falling TCK edge. tdo_oe_o is high only in Shift-IR and Shift-DR.
- R10: The TAP follows the 16-state IEEE 1149.1 graph on rising TCK edges, including the Exit1/Pause/Exit2 loop back into Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock, also the flash serial clock source |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| tdo_o | output | 1 | Test data out |
| tdo_oe_o | output | 1 | TDO drive enable, low means high-impedance |
| spi_sclk_o | output | 1 | Gated serial clock to the flash |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| spi_cs_no | output | 1 | Active-low flash chip select |

## Verification
spi_cs_no and spi_mosi_o follow a rising TCK edge combinationally. tdo_o and tdo_oe_o settle at the falling edge that follows. A new instruction takes effect at the falling edge in Update-IR, and the serial clock gate opens at the first falling edge in Shift-DR. The bench therefore moves TMS and TDI 1 ns after a falling edge and samples every output 1 ns after the next falling edge, so each result is read half a cycle after the rising edge that caused it. One probe samples tdo_o between the rising and the falling edge to confirm it has not yet moved. Flash-side bits are counted and collected on spi_sclk_o itself.

// File: rtl/jsb_pkg.sv
package jsb_pkg;
  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SHIFT_DR, TAP_EXIT1_DR, TAP_PAUSE_DR, TAP_EXIT2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SHIFT_IR, TAP_EXIT1_IR, TAP_PAUSE_IR, TAP_EXIT2_IR, TAP_UPD_IR
  } tap_state_e;

  localparam int unsigned IR_W_DEF      = 6;
  localparam int unsigned TMS_RESET_LEN = 5;
endpackage

// File: rtl/jsb_tap_ctrl.sv
module jsb_tap_ctrl
  import jsb_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  localparam int unsigned CNT_W = $clog2(TMS_RESET_LEN + 1);

  tap_state_e state_q, state_d;
  logic [CNT_W-1:0] ones_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TAP_RESET:    state_d = tms_i ? TAP_RESET    : TAP_IDLE;
      TAP_IDLE:     state_d = tms_i ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_DR:   state_d = tms_i ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   state_d = tms_i ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: state_d = tms_i ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_EXIT1_DR: state_d = tms_i ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: state_d = tms_i ? TAP_EXIT2_DR : TAP_PAUSE_DR;
      TAP_EXIT2_DR: state_d = tms_i ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   state_d = tms_i ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_IR:   state_d = tms_i ? TAP_RESET    : TAP_CAP_IR;
      TAP_CAP_IR:   state_d = tms_i ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: state_d = tms_i ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_EXIT1_IR: state_d = tms_i ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: state_d = tms_i ? TAP_EXIT2_IR : TAP_PAUSE_IR;
      TAP_EXIT2_IR: state_d = tms_i ? TAP_UPD_IR   : TAP_SHIFT_IR;
      TAP_UPD_IR:   state_d = tms_i ? TAP_SEL_DR   : TAP_IDLE;
      default:      state_d = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TAP_RESET;
    else         state_q <= state_d;
  end

  // run length of TMS=1, checked against the reset guarantee
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                              ones_q <= '0;
    else if (!tms_i)                          ones_q <= '0;
    else if (ones_q != CNT_W'(TMS_RESET_LEN)) ones_q <= ones_q + 1'b1;
  end

  assign state_o = state_q;

  // R2
  tms_reset_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q == CNT_W'(TMS_RESET_LEN)) |-> (state_q == TAP_RESET));

  // R10
  idle_entry_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TAP_RESET && !tms_i) |=> (state_q == TAP_IDLE));
endmodule

// File: rtl/jsb_ir.sv
module jsb_ir
  import jsb_pkg::*;
#(
  parameter int unsigned IR_W = IR_W_DEF
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            sr_lsb_o
);
  localparam logic [IR_W-1:0] CAPTURE_VAL = IR_W'(1);

  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                      sr_q <= '0;
    else if (state_i == TAP_CAP_IR)   sr_q <= CAPTURE_VAL;
    else if (state_i == TAP_SHIFT_IR) sr_q <= {tdi_i, sr_q[IR_W-1:1]};
  end

  // active instruction moves on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                    ir_q <= '1;
    else if (state_i == TAP_RESET)  ir_q <= '1;
    else if (state_i == TAP_UPD_IR) ir_q <= sr_q;
  end

  assign ir_o     = ir_q;
  assign sr_lsb_o = sr_q[0];

  // R3
  ir_capture_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TAP_CAP_IR) |=> (sr_q == CAPTURE_VAL));

  // R3
  ir_update_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TAP_UPD_IR) |=> (ir_q == $past(sr_q)));
endmodule

// File: rtl/jsb_dr_path.sv
module jsb_dr_path
  import jsb_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       bridge_i,
  input  logic       tdi_i,
  input  logic       miso_i,
  input  logic       ir_lsb_i,
  output logic       tdo_o,
  output logic       tdo_oe_o,
  output logic       cs_no,
  output logic       sclk_o,
  output logic       mosi_o
);
  logic byp_q, tdo_q, oe_q, clk_en_q;
  logic flash_sel, tdo_d;

  assign flash_sel = bridge_i && (state_i == TAP_SHIFT_DR);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                      byp_q <= 1'b0;
    else if (state_i == TAP_CAP_DR)   byp_q <= 1'b0;
    else if (state_i == TAP_SHIFT_DR) byp_q <= tdi_i;
  end

  always_comb begin
    tdo_d = tdo_q;
    if (state_i == TAP_SHIFT_IR)      tdo_d = ir_lsb_i;
    else if (state_i == TAP_SHIFT_DR) tdo_d = bridge_i ? miso_i : byp_q;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b1;
      oe_q     <= 1'b0;
      clk_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      oe_q     <= (state_i == TAP_SHIFT_IR) || (state_i == TAP_SHIFT_DR);
      clk_en_q <= flash_sel;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;
  assign cs_no    = ~flash_sel;
  assign sclk_o   = tck_i & clk_en_q;
  assign mosi_o   = bridge_i ? tdi_i : 1'b0;

  // R8
  bypass_capture_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TAP_CAP_DR) |=> (byp_q == 1'b0));

  // R7
  sclk_gate_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    clk_en_q |-> (bridge_i && state_i == TAP_SHIFT_DR));

  // R9
  tdo_enable_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    oe_q |-> (state_i == TAP_SHIFT_IR || state_i == TAP_SHIFT_DR));
endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
  import jsb_pkg::*;
#(
  parameter int unsigned     IR_W        = IR_W_DEF,
  parameter logic [IR_W-1:0] BRIDGE_CODE = IR_W'('h02)
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o,
  output logic tdo_oe_o,
  output logic spi_sclk_o,
  output logic spi_mosi_o,
  input  logic spi_miso_i,
  output logic spi_cs_no
);
  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_lsb;
  logic            bridge_sel;

  jsb_tap_ctrl u_tap (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  jsb_ir #(.IR_W(IR_W)) u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .tdi_i    (tdi_i),
    .ir_o     (ir),
    .sr_lsb_o (ir_lsb)
  );

  assign bridge_sel = (ir == BRIDGE_CODE);

  jsb_dr_path u_dr (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .bridge_i (bridge_sel),
    .tdi_i    (tdi_i),
    .miso_i   (spi_miso_i),
    .ir_lsb_i (ir_lsb),
    .tdo_o    (tdo_o),
    .tdo_oe_o (tdo_oe_o),
    .cs_no    (spi_cs_no),
    .sclk_o   (spi_sclk_o),
    .mosi_o   (spi_mosi_o)
  );

  // R4
  cs_entry_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> ($past(state) == TAP_CAP_DR || $past(state) == TAP_EXIT2_DR));
endmodule

// File: tb/tb_jtag_spi_bridge.sv
module tb_jtag_spi_bridge;
  timeunit 1ns;
  timeprecision 1ps;

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0, miso = 1'b0;
  logic tdo, oe, sclk, mosi, cs_n;
  int   n_cmp = 0, n_bad = 0, rises = 0;
  logic [7:0] rx = '0;

  jtag_spi_bridge dut (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_oe_o(oe), .spi_sclk_o(sclk), .spi_mosi_o(mosi),
    .spi_miso_i(miso), .spi_cs_no(cs_n)
  );

  always #2 tck = ~tck;

  // flash side: count clocks and collect MOSI
  always @(posedge sclk) begin
    rises++;
    rx = {rx[6:0], mosi};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [5:0] code);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 6; i++) begin
      chk("R3 captured bit on tdo", tdo, (i == 0) ? 1 : 0);
      chk("R9 oe in Shift-IR", oe, 1);
      chk("R4 cs_n in Shift-IR", cs_n, 1);
      step(i == 5, code[i]);
    end
    chk("R9 oe in Exit1-IR", oe, 0);
    step(1, 0); step(0, 0);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge tck);
    #1;
    chk("R1 cs_n in reset", cs_n, 1);
    chk("R1 oe in reset", oe, 0);
    @(posedge tck); #0.5;
    chk("R1 sclk in reset", sclk, 0);
    rst_n = 1'b1;
    @(negedge tck); #1;
    step(0, 0);
  endtask

  task automatic test_bypass(input logic [5:0] code);
    logic [7:0] p = 8'b0100_1101;
    int r0;
    load_ir(code);
    r0 = rises;
    step(1, 0); step(0, 0); step(0, 1);
    chk("R8 bypass captured 0", tdo, 0);
    chk("R8 cs_n stays high", cs_n, 1);
    chk("R5 mosi held low", mosi, 0);
    tms = 0; tdi = p[0];
    @(posedge tck); #0.5;
    chk("R9 tdo holds until falling edge", tdo, 0);
    @(negedge tck); #1;
    chk("R8 bypass echo bit 0", tdo, p[0]);
    for (int i = 1; i < 7; i++) begin
      step(0, p[i]);
      chk("R8 bypass echo", tdo, p[i]);
    end
    step(1, 1);
    chk("R7 no sclk under bypass", rises - r0, 0);
    step(1, 0); step(0, 0);
    chk("R9 oe low in idle", oe, 0);
  endtask

  task automatic test_bridge(input logic [7:0] d, input logic [7:0] m);
    int r0 = rises;
    step(1, 0); step(0, 0);
    chk("R4 cs_n in Capture-DR", cs_n, 1);
    miso = m[7];
    step(0, 0);
    chk("R4 cs_n low in bridge Shift-DR", cs_n, 0);
    chk("R6 first miso bit", tdo, m[7]);
    chk("R7 no sclk edge before shift", rises - r0, 0);
    for (int i = 0; i < 8; i++) begin
      if (i < 7) miso = m[6-i];
      step(i == 7, d[7-i]);
      if (i < 7) begin
        chk("R6 tdo follows miso", tdo, m[6-i]);
        chk("R5 mosi follows tdi", mosi, d[7-i]);
      end
    end
    chk("R4 cs_n in Exit1-DR", cs_n, 1);
    chk("R7 one sclk rise per bit", rises - r0, 8);
    chk("R5 flash received byte", rx, d);
    step(1, 0); step(0, 0);
  endtask

  task automatic test_pause;
    int r0;
    step(1, 0); step(0, 0); step(0, 0);
    step(0, 1);
    step(1, 0);
    chk("R4 cs_n in Exit1-DR", cs_n, 1);
    step(0, 0);
    chk("R4 cs_n in Pause-DR", cs_n, 1);
    chk("R9 oe in Pause-DR", oe, 0);
    r0 = rises;
    step(0, 0);
    chk("R7 no sclk in Pause-DR", rises - r0, 0);
    step(1, 0);
    step(0, 0);
    chk("R10 back to Shift-DR via Exit2", cs_n, 0);
    step(1, 0); step(1, 0); step(0, 0);
  endtask

  task automatic check_bypass_after_reset(input string req);
    step(1, 0); step(0, 0); step(0, 1);
    chk(req, cs_n, 1);
    step(0, 1);
    chk("R8 bypass echo after reset", tdo, 1);
    step(1, 0); step(1, 0); step(0, 0);
  endtask

  task automatic test_tms_reset;
    step(1, 0); step(0, 0); step(0, 0);
    chk("R4 cs_n low before TMS reset", cs_n, 0);
    repeat (5) step(1, 0);
    chk("R2 cs_n after five TMS ones", cs_n, 1);
    step(0, 0);
    check_bypass_after_reset("R2 IR back to bypass");
  endtask

  task automatic test_trst;
    load_ir(6'h02);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R4 cs_n low before TRST", cs_n, 0);
    rst_n = 1'b0;
    #0.5;
    chk("R1 cs_n async", cs_n, 1);
    chk("R1 oe async", oe, 0);
    chk("R1 sclk async", sclk, 0);
    #1;
    rst_n = 1'b1;
    tms = 1'b1;
    @(negedge tck); #1;
    step(0, 0);
    check_bypass_after_reset("R1 IR bypass after TRST");
  endtask

  initial begin
    #800000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    test_bypass(6'h3f);
    test_bypass(6'h03);
    load_ir(6'h02);
    test_bridge(8'hA5, 8'h3C);
    test_bridge(8'h0F, 8'hF1);
    test_pause();
    test_tms_reset();
    test_trst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule